// File: doc/BRIEF.md
# Odd-parity Hamming BCD codec

This block guards single decimal digits with a seven-bit Hamming code. The check bits are chosen so that every check group holds an odd number of ones. As a result, a word of all zeros is never a legal codeword, and a stuck-low bus shows up as an error instead of passing as a digit.

The block has two independent paths, and each is registered once.

- **Encode path:** takes a four-bit digit and returns its seven-bit codeword. It flags any value above nine as an invalid digit.
- **Decode path:** takes a seven-bit word and forms a three-bit syndrome. It inverts the single position that the syndrome names and returns the repaired digit. It also returns the syndrome, a flag that a repair took place, and a flag that the repaired value is not a decimal digit.

Each path has a one-cycle valid strobe, and both share one synchronous reset. A double-bit error is repaired to a wrong codeword. That is accepted behaviour and is not detected.

Top module: `hbcd_codec`

## Requirements
- R1: Codeword bit i (port index 0 to 6) is code position i+1. Positions 1, 2 and 4 are check bits. Positions 3, 5, 6 and 7 hold the digit from its most significant bit to its least. Each check bit makes its group odd: the group for position 1 is {1,3,5,7}, for position 2 is {2,3,6,7}, and for position 4 is {4,5,6,7}.
- R2: Written as positions 1 to 7, the encoder gives these codewords: digit 0 gives 1101000, 5 gives 1001101, 7 gives 1100111, 8 gives 0011000 and 9 gives 1110001.
- R3: The encoder's invalid-digit flag is 1 exactly when the input digit is 10 to 15. The codeword is still produced by the same rule as in R1.
- R4: A decoder input whose three groups are all odd gives syndrome 0 and repair flag 0. The output digit is the one read from positions 3, 5, 6 and 7.
- R5: If a legal codeword has exactly one position k (1 to 7) inverted, the decoder gives syndrome k and repair flag 1, and returns the original digit.
- R6: The decoder's invalid-digit flag is 1 exactly when the repaired digit exceeds 9.
- R7: Each output set and its valid strobe appear on the first rising edge after a valid input. In a cycle with no valid input, the valid strobe is 0 and the data and flags hold their last values. Inputs that are valid back to back give results on back-to-back cycles.
- R8: While reset is high at a rising edge, every output is cleared to 0.
- R9: The all-zero input word decodes with syndrome 7 and repair flag 1, which gives digit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| enc_valid_i | input | 1 | Encode request this cycle |
| enc_digit_i | input | 4 | Digit to encode |
| enc_valid_o | output | 1 | Encode result strobe |
| enc_code_o | output | 7 | Codeword, bit i is position i+1 |
| enc_bad_o | output | 1 | Encoded input was above 9 |
| dec_valid_i | input | 1 | Decode request this cycle |
| dec_code_i | input | 7 | Received word, bit i is position i+1 |
| dec_valid_o | output | 1 | Decode result strobe |
| dec_digit_o | output | 4 | Repaired digit |
| dec_syndrome_o | output | 3 | Syndrome, the index of the inverted position |
| dec_fixed_o | output | 1 | A position was inverted |
| dec_bad_o | output | 1 | Repaired digit above 9 |

## Verification
Each path has only one register stage. A wrong group mask, syndrome match or data-position map therefore shows at the ports on the cycle right after the offending request. It shows as a wrong codeword, a wrong syndrome, or a digit that was not restored. The bench sweeps all 16 encoder inputs and all 70 single-error words of the ten digits, so every position of every group is exercised. A register that loads on idle cycles shows on the next idle cycle as changed held data. A lost or extra strobe shows in the strobe checked beside every result.

// File: rtl/hbcd_pkg.sv
package hbcd_pkg;

   localparam int unsigned HB_PAR_W_DFLT     = 3;
   localparam int unsigned HB_MAX_DIGIT_DFLT = 9;

   function automatic int unsigned hb_code_w(input int unsigned par_w);
      return (1 << par_w) - 1;
   endfunction

   function automatic int unsigned hb_data_w(input int unsigned par_w);
      return hb_code_w(par_w) - par_w;
   endfunction

   function automatic bit hb_is_check_pos(input int unsigned p);
      return (p != 0) && ((p & (p - 1)) == 0);
   endfunction

   // 1-based position of the j-th data slot (j = 0 is the most significant digit bit)
   function automatic int unsigned hb_data_pos(input int unsigned j);
      int unsigned seen;
      int unsigned found;
      seen  = 0;
      found = 0;
      for (int unsigned p = 1; p < 64; p++) begin
         if (!hb_is_check_pos(p) && found == 0) begin
            if (seen == j) found = p;
            seen++;
         end
      end
      return found;
   endfunction

   // bit p-1 set when position p belongs to check group k
   function automatic logic [31:0] hb_group_mask(input int unsigned k, input int unsigned code_w);
      logic [31:0] m;
      m = '0;
      for (int unsigned p = 1; p <= code_w; p++) begin
         if (((p >> k) & 1) == 1) m[p-1] = 1'b1;
      end
      return m;
   endfunction

   typedef struct packed {
      logic fixed;
      logic bad;
   } hb_dec_flags_t;

endpackage

// File: rtl/hbcd_group_xor.sv
module hbcd_group_xor #(
   parameter int unsigned PAR_W  = hbcd_pkg::HB_PAR_W_DFLT,
   localparam int unsigned CODE_W = hbcd_pkg::hb_code_w(PAR_W)
) (
   input  logic [CODE_W-1:0] word_i,
   output logic [PAR_W-1:0]  grp_o
);

   if (PAR_W < 2 || PAR_W > 5) begin : g_bad_par
      $error("hbcd_group_xor: PAR_W must lie in 2..5");
   end

   for (genvar k = 0; k < PAR_W; k++) begin : g_grp
      localparam logic [31:0] MASK = hbcd_pkg::hb_group_mask(k, CODE_W);
      assign grp_o[k] = ^(word_i & MASK[CODE_W-1:0]);
   end

endmodule

// File: rtl/hbcd_encoder.sv
module hbcd_encoder #(
   parameter int unsigned PAR_W      = hbcd_pkg::HB_PAR_W_DFLT,
   parameter int unsigned MAX_DIGIT  = hbcd_pkg::HB_MAX_DIGIT_DFLT,
   parameter bit          ODD_PARITY = 1'b1,
   localparam int unsigned CODE_W = hbcd_pkg::hb_code_w(PAR_W),
   localparam int unsigned DATA_W = hbcd_pkg::hb_data_w(PAR_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid_i,
   input  logic [DATA_W-1:0] digit_i,
   output logic              valid_o,
   output logic [CODE_W-1:0] code_o,
   output logic              bad_o
);

   localparam logic [DATA_W-1:0] MAX_D = DATA_W'(MAX_DIGIT);

   if (MAX_DIGIT >= (1 << DATA_W)) begin : g_bad_max
      $error("hbcd_encoder: MAX_DIGIT does not fit the data width");
   end

   logic [CODE_W-1:0] spread;
   logic [CODE_W-1:0] code_c;
   logic [PAR_W-1:0]  grp;

   for (genvar j = 0; j < DATA_W; j++) begin : g_data
      localparam int unsigned POS = hbcd_pkg::hb_data_pos(j);
      assign spread[POS-1] = digit_i[DATA_W-1-j];
      assign code_c[POS-1] = digit_i[DATA_W-1-j];
   end

   for (genvar k = 0; k < PAR_W; k++) begin : g_chk
      assign spread[(1 << k) - 1] = 1'b0;
      assign code_c[(1 << k) - 1] = grp[k] ^ ODD_PARITY;
   end

   hbcd_group_xor #(.PAR_W(PAR_W)) u_grp (
      .word_i (spread),
      .grp_o  (grp)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_o <= 1'b0;
         code_o  <= '0;
         bad_o   <= 1'b0;
      end else begin
         valid_o <= valid_i;
         if (valid_i) begin
            code_o <= code_c;
            bad_o  <= (digit_i > MAX_D);
         end
      end
   end

   for (genvar k = 0; k < PAR_W; k++) begin : g_ast_grp
      localparam logic [31:0] MASK = hbcd_pkg::hb_group_mask(k, CODE_W);
      AST_ENC_GROUP_SENSE: assert property (@(posedge clk) disable iff (rst)
         valid_o |-> (1'($countones(code_o & MASK[CODE_W-1:0])) == ODD_PARITY)); // R1
   end

   AST_ENC_STROBE: assert property (@(posedge clk) disable iff (rst)
      valid_i |=> valid_o); // R7
   AST_ENC_IDLE: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> (!valid_o && $stable(code_o) && $stable(bad_o))); // R7
   AST_ENC_RANGE: assert property (@(posedge clk) disable iff (rst)
      valid_i |=> (bad_o == ($past(digit_i) > MAX_D))); // R3

endmodule

// File: rtl/hbcd_decoder.sv
module hbcd_decoder #(
   parameter int unsigned PAR_W      = hbcd_pkg::HB_PAR_W_DFLT,
   parameter int unsigned MAX_DIGIT  = hbcd_pkg::HB_MAX_DIGIT_DFLT,
   parameter bit          ODD_PARITY = 1'b1,
   localparam int unsigned CODE_W = hbcd_pkg::hb_code_w(PAR_W),
   localparam int unsigned DATA_W = hbcd_pkg::hb_data_w(PAR_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] digit_o,
   output logic [PAR_W-1:0]  syndrome_o,
   output logic              fixed_o,
   output logic              bad_o
);

   localparam logic [DATA_W-1:0] MAX_D = DATA_W'(MAX_DIGIT);

   if (MAX_DIGIT >= (1 << DATA_W)) begin : g_bad_max
      $error("hbcd_decoder: MAX_DIGIT does not fit the data width");
   end

   logic [PAR_W-1:0]      grp;
   logic [PAR_W-1:0]      syn;
   logic [CODE_W-1:0]     flip;
   logic [CODE_W-1:0]     repaired;
   logic [DATA_W-1:0]     digit_c;
   hbcd_pkg::hb_dec_flags_t flags_c;

   hbcd_group_xor #(.PAR_W(PAR_W)) u_grp (
      .word_i (code_i),
      .grp_o  (grp)
   );

   // a group whose parity is already right contributes a zero syndrome bit
   assign syn = grp ^ {PAR_W{ODD_PARITY}};

   for (genvar p = 1; p <= CODE_W; p++) begin : g_flip
      assign flip[p-1] = (syn == PAR_W'(p));
   end

   assign repaired = code_i ^ flip;

   for (genvar j = 0; j < DATA_W; j++) begin : g_extract
      localparam int unsigned POS = hbcd_pkg::hb_data_pos(j);
      assign digit_c[DATA_W-1-j] = repaired[POS-1];
   end

   always_comb begin
      flags_c.fixed = |syn;
      flags_c.bad   = (digit_c > MAX_D);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_o    <= 1'b0;
         digit_o    <= '0;
         syndrome_o <= '0;
         fixed_o    <= 1'b0;
         bad_o      <= 1'b0;
      end else begin
         valid_o <= valid_i;
         if (valid_i) begin
            digit_o    <= digit_c;
            syndrome_o <= syn;
            fixed_o    <= flags_c.fixed;
            bad_o      <= flags_c.bad;
         end
      end
   end

   logic [PAR_W-1:0] in_ok;
   for (genvar k = 0; k < PAR_W; k++) begin : g_ast_in
      localparam logic [31:0] MASK = hbcd_pkg::hb_group_mask(k, CODE_W);
      assign in_ok[k] = (1'($countones(code_i & MASK[CODE_W-1:0])) == ODD_PARITY);
   end

   AST_DEC_CLEAN_PASS: assert property (@(posedge clk) disable iff (rst)
      (valid_i && (&in_ok)) |=> (!fixed_o && syndrome_o == '0)); // R4
   AST_DEC_DIRTY_FIX: assert property (@(posedge clk) disable iff (rst)
      (valid_i && !(&in_ok)) |=> (fixed_o && syndrome_o != '0)); // R5
   AST_DEC_RANGE: assert property (@(posedge clk) disable iff (rst)
      (valid_o && !bad_o) |-> (digit_o <= MAX_D)); // R6
   AST_DEC_STROBE: assert property (@(posedge clk) disable iff (rst)
      valid_i |=> valid_o); // R7
   AST_DEC_IDLE: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> (!valid_o && $stable(digit_o) && $stable(syndrome_o))); // R7

endmodule

// File: rtl/hbcd_codec.sv
module hbcd_codec #(
   parameter int unsigned PAR_W      = hbcd_pkg::HB_PAR_W_DFLT,
   parameter int unsigned MAX_DIGIT  = hbcd_pkg::HB_MAX_DIGIT_DFLT,
   parameter bit          ODD_PARITY = 1'b1,
   localparam int unsigned CODE_W = hbcd_pkg::hb_code_w(PAR_W),
   localparam int unsigned DATA_W = hbcd_pkg::hb_data_w(PAR_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              enc_valid_i,
   input  logic [DATA_W-1:0] enc_digit_i,
   output logic              enc_valid_o,
   output logic [CODE_W-1:0] enc_code_o,
   output logic              enc_bad_o,
   input  logic              dec_valid_i,
   input  logic [CODE_W-1:0] dec_code_i,
   output logic              dec_valid_o,
   output logic [DATA_W-1:0] dec_digit_o,
   output logic [PAR_W-1:0]  dec_syndrome_o,
   output logic              dec_fixed_o,
   output logic              dec_bad_o
);

   hbcd_encoder #(
      .PAR_W      (PAR_W),
      .MAX_DIGIT  (MAX_DIGIT),
      .ODD_PARITY (ODD_PARITY)
   ) u_enc (
      .clk     (clk),
      .rst     (rst),
      .valid_i (enc_valid_i),
      .digit_i (enc_digit_i),
      .valid_o (enc_valid_o),
      .code_o  (enc_code_o),
      .bad_o   (enc_bad_o)
   );

   hbcd_decoder #(
      .PAR_W      (PAR_W),
      .MAX_DIGIT  (MAX_DIGIT),
      .ODD_PARITY (ODD_PARITY)
   ) u_dec (
      .clk        (clk),
      .rst        (rst),
      .valid_i    (dec_valid_i),
      .code_i     (dec_code_i),
      .valid_o    (dec_valid_o),
      .digit_o    (dec_digit_o),
      .syndrome_o (dec_syndrome_o),
      .fixed_o    (dec_fixed_o),
      .bad_o      (dec_bad_o)
   );

   AST_ALLZERO_REJECT: assert property (@(posedge clk) disable iff (rst)
      (dec_valid_i && dec_code_i == '0) |=> dec_fixed_o); // R9

endmodule

// File: tb/hbcd_codec_bench.sv
module hbcd_codec_bench;

   logic       clk = 1'b0;
   logic       rst;
   logic       enc_valid_i;
   logic [3:0] enc_digit_i;
   logic       enc_valid_o;
   logic [6:0] enc_code_o;
   logic       enc_bad_o;
   logic       dec_valid_i;
   logic [6:0] dec_code_i;
   logic       dec_valid_o;
   logic [3:0] dec_digit_o;
   logic [2:0] dec_syndrome_o;
   logic       dec_fixed_o;
   logic       dec_bad_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   hbcd_codec u_hbcd_codec (
      .clk            (clk),
      .rst            (rst),
      .enc_valid_i    (enc_valid_i),
      .enc_digit_i    (enc_digit_i),
      .enc_valid_o    (enc_valid_o),
      .enc_code_o     (enc_code_o),
      .enc_bad_o      (enc_bad_o),
      .dec_valid_i    (dec_valid_i),
      .dec_code_i     (dec_code_i),
      .dec_valid_o    (dec_valid_o),
      .dec_digit_o    (dec_digit_o),
      .dec_syndrome_o (dec_syndrome_o),
      .dec_fixed_o    (dec_fixed_o),
      .dec_bad_o      (dec_bad_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // position p of the returned word sits at bit p-1; every group gets an odd count
   function automatic logic [6:0] model_code(input logic [3:0] d);
      logic [7:1] pos;
      int         c1, c2, c4;
      pos[3] = d[3];
      pos[5] = d[2];
      pos[6] = d[1];
      pos[7] = d[0];
      c1 = int'(pos[3]) + int'(pos[5]) + int'(pos[7]);
      c2 = int'(pos[3]) + int'(pos[6]) + int'(pos[7]);
      c4 = int'(pos[5]) + int'(pos[6]) + int'(pos[7]);
      pos[1] = (c1 % 2 == 0);
      pos[2] = (c2 % 2 == 0);
      pos[4] = (c4 % 2 == 0);
      return pos[7:1];
   endfunction

   // literal written as positions 1..7, left to right
   function automatic logic [6:0] from_pos_order(input logic [6:0] s);
      logic [6:0] r;
      for (int i = 0; i < 7; i++) r[i] = s[6-i];
      return r;
   endfunction

   task automatic enc_send(input logic [3:0] d);
      @(negedge clk);
      enc_valid_i = 1'b1;
      enc_digit_i = d;
      @(negedge clk);
      enc_valid_i = 1'b0;
   endtask

   task automatic dec_send(input logic [6:0] w);
      @(negedge clk);
      dec_valid_i = 1'b1;
      dec_code_i  = w;
      @(negedge clk);
      dec_valid_i = 1'b0;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst         = 1'b1;
      enc_valid_i = 1'b0;
      enc_digit_i = '0;
      dec_valid_i = 1'b0;
      dec_code_i  = '0;
      repeat (3) @(negedge clk);
      // R8 reset state
      chk("R8", "enc_valid_o", int'(enc_valid_o), 0);
      chk("R8", "enc_code_o", int'(enc_code_o), 0);
      chk("R8", "dec_valid_o", int'(dec_valid_o), 0);
      chk("R8", "dec_digit_o", int'(dec_digit_o), 0);
      chk("R8", "dec_syndrome_o", int'(dec_syndrome_o), 0);
      rst = 1'b0;

      // R1 R3 R7: full encoder sweep
      for (int d = 0; d < 16; d++) begin
         enc_send(4'(d));
         chk("R7", "enc_valid_o", int'(enc_valid_o), 1);
         chk("R1", $sformatf("code of %0d", d), int'(enc_code_o), int'(model_code(4'(d))));
         chk("R3", $sformatf("bad of %0d", d), int'(enc_bad_o), (d > 9) ? 1 : 0);
      end
      // R7 idle cycle holds the last result
      @(negedge clk);
      chk("R7", "enc_valid_o idle", int'(enc_valid_o), 0);
      chk("R7", "enc_code_o held", int'(enc_code_o), int'(model_code(4'd15)));
      chk("R7", "enc_bad_o held", int'(enc_bad_o), 1);

      // R2 fixed vectors
      enc_send(4'd0); chk("R2", "digit 0", int'(enc_code_o), int'(from_pos_order(7'b1101000)));
      enc_send(4'd5); chk("R2", "digit 5", int'(enc_code_o), int'(from_pos_order(7'b1001101)));
      enc_send(4'd7); chk("R2", "digit 7", int'(enc_code_o), int'(from_pos_order(7'b1100111)));
      enc_send(4'd8); chk("R2", "digit 8", int'(enc_code_o), int'(from_pos_order(7'b0011000)));
      enc_send(4'd9); chk("R2", "digit 9", int'(enc_code_o), int'(from_pos_order(7'b1110001)));

      // R4 clean words, R5 every single-bit error of every digit
      for (int d = 0; d < 10; d++) begin
         dec_send(model_code(4'(d)));
         chk("R7", "dec_valid_o", int'(dec_valid_o), 1);
         chk("R4", $sformatf("syndrome clean %0d", d), int'(dec_syndrome_o), 0);
         chk("R4", $sformatf("fixed clean %0d", d), int'(dec_fixed_o), 0);
         chk("R4", $sformatf("digit clean %0d", d), int'(dec_digit_o), d);
         chk("R6", $sformatf("bad clean %0d", d), int'(dec_bad_o), 0);
         for (int p = 1; p <= 7; p++) begin
            dec_send(model_code(4'(d)) ^ (7'd1 << (p - 1)));
            chk("R5", $sformatf("syndrome d%0d p%0d", d, p), int'(dec_syndrome_o), p);
            chk("R5", $sformatf("fixed d%0d p%0d", d, p), int'(dec_fixed_o), 1);
            chk("R5", $sformatf("digit d%0d p%0d", d, p), int'(dec_digit_o), d);
            chk("R6", $sformatf("bad d%0d p%0d", d, p), int'(dec_bad_o), 0);
         end
      end

      // R6 out-of-range values, clean and with one inverted position
      for (int d = 10; d < 16; d++) begin
         dec_send(model_code(4'(d)));
         chk("R6", $sformatf("bad clean %0d", d), int'(dec_bad_o), 1);
         chk("R6", $sformatf("digit clean %0d", d), int'(dec_digit_o), d);
         dec_send(model_code(4'(d)) ^ 7'b0000100);
         chk("R6", $sformatf("bad fixed %0d", d), int'(dec_bad_o), 1);
         chk("R5", $sformatf("syndrome p3 %0d", d), int'(dec_syndrome_o), 3);
      end

      // R9 all-zero word
      dec_send(7'd0);
      chk("R9", "syndrome", int'(dec_syndrome_o), 7);
      chk("R9", "fixed", int'(dec_fixed_o), 1);
      chk("R9", "digit", int'(dec_digit_o), 1);
      @(negedge clk);
      chk("R7", "dec_valid_o idle", int'(dec_valid_o), 0);
      chk("R7", "dec_digit_o held", int'(dec_digit_o), 1);

      // R7 back-to-back on both paths
      @(negedge clk);
      enc_valid_i = 1'b1; enc_digit_i = 4'd3;
      dec_valid_i = 1'b1; dec_code_i = model_code(4'd6) ^ 7'b0100000;
      @(negedge clk);
      chk("R7", "b2b enc first", int'(enc_code_o), int'(model_code(4'd3)));
      chk("R7", "b2b dec first", int'(dec_digit_o), 6);
      enc_digit_i = 4'd4;
      dec_code_i  = model_code(4'd2);
      @(negedge clk);
      enc_valid_i = 1'b0;
      dec_valid_i = 1'b0;
      chk("R7", "b2b enc second valid", int'(enc_valid_o), 1);
      chk("R7", "b2b enc second", int'(enc_code_o), int'(model_code(4'd4)));
      chk("R7", "b2b dec second", int'(dec_digit_o), 2);
      chk("R7", "b2b dec second fixed", int'(dec_fixed_o), 0);
      @(negedge clk);
      chk("R7", "b2b enc drop", int'(enc_valid_o), 0);

      // R8 reset mid-run
      enc_send(4'd9);
      dec_send(7'd0);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R8", "mid enc_code_o", int'(enc_code_o), 0);
      chk("R8", "mid enc_bad_o", int'(enc_bad_o), 0);
      chk("R8", "mid dec_digit_o", int'(dec_digit_o), 0);
      chk("R8", "mid dec_fixed_o", int'(dec_fixed_o), 0);
      chk("R8", "mid dec_syndrome_o", int'(dec_syndrome_o), 0);
      rst = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule